// File: doc/BRIEF.md
# Differential PWM Bridge Decoder

This block takes one audio channel's pair of logic-level PWM bits and turns them into the four switch commands of a bridge-tied load. The bridge has two legs, plus and minus. Each leg has a switch to supply (high side) and a switch to ground (low side). The pair of PWM bits selects one of four bridge modes:

- **Damped:** both legs go to ground.
- **Positive drive:** the plus leg goes to supply and the minus leg goes to ground.
- **Negative drive:** the plus leg goes to ground and the minus leg goes to supply.
- **Both high:** both legs go to supply. This code is unused in practice but is still decoded deterministically.

Before a leg changes side, both of its switches are held off for a programmable dead time. Every switch pulse lasts at least a minimum width, so a request that is too short is stretched instead of being dropped. When the synchronized enable is low, every switch is off and both outputs float.

The enable and both PWM bits pass through a two-flop synchronizer before they are used. Gate commands come straight from registers, so the delay from an input pin to the first gate change is fixed. A stereo device uses two instances of the block. Level shifting, the analog drivers and the output filter sit outside this block.

The block has no detection of a PWM input stuck at one level. A constant input produces a constant bridge state for as long as it is applied.

Top module: `pwm_bridge_decoder`

## Requirements
- R1: While the enable is low, all four gate outputs are 0 from the third clock edge after the enable falls, whatever the PWM bits do.
- R2: With the enable high and both PWM bits at 0, the steady outputs are a_lo=1 and b_lo=1, with a_hi=0 and b_hi=0 (damped).
- R3: With pwm_p=1 and pwm_n=0, the steady outputs are a_hi=1 and b_lo=1; the other two are 0 (positive drive).
- R4: With pwm_p=0 and pwm_n=1, the steady outputs are a_lo=1 and b_hi=1; the other two are 0 (negative drive).
- R5: With both PWM bits at 1, the steady outputs are a_hi=1 and b_hi=1; the other two are 0.
- R6: The high and low switch of a leg are never on in the same cycle. During reset all four outputs are 0.
- R7: When a leg changes side while enabled, both of its switches are off for exactly DEAD_CYC cycles between the two on-periods.
- R8: While enabled, every switch stays on for at least MIN_PW_CYC cycles. A side request of a single cycle still produces an on-pulse of exactly MIN_PW_CYC cycles.
- R9: A change on a PWM pin makes the first gate change (the leg's turn-off) visible after the third rising clock edge.
- R10: A constant input pattern gives constant gate outputs indefinitely. No timeout acts on a stuck input.
- R11: When the enable rises while the legs are off, the requested switches turn on at the (3+DEAD_CYC)-th rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Bridge enable. Low means all switches off (mute) |
| pwm_p | input | 1 | Plus bit of the differential PWM pair |
| pwm_n | input | 1 | Minus bit of the differential PWM pair |
| a_hi | output | 1 | Plus leg, switch to supply |
| a_lo | output | 1 | Plus leg, switch to ground |
| b_hi | output | 1 | Minus leg, switch to supply |
| b_lo | output | 1 | Minus leg, switch to ground |

## Verification
The hardest case to reach from the pins is a request that reverses during the dead time. The leg must then finish the side change it has already committed to and stretch the new pulse, rather than fall back to the old side. The bench reaches this case in two ways. A directed one-cycle glitch on pwm_p hits a long-settled leg. A long pseudo-random phase toggles the PWM bits and the enable faster than the dead time plus the minimum width. In that phase a behavioural model predicts all four gates on every cycle.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;

  localparam int NUM_LEGS  = 2;
  localparam int LEG_PLUS  = 0;
  localparam int LEG_MINUS = 1;

  typedef enum logic [1:0] {
    MODE_DAMPED  = 2'b00,
    MODE_NEG     = 2'b01,
    MODE_POS     = 2'b10,
    MODE_BOTH_HI = 2'b11
  } bridge_mode_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } leg_gate_t;

  // {plus bit, minus bit} -> bridge mode
  function automatic bridge_mode_e decode_mode(input logic p, input logic n);
    case ({p, n})
      2'b10:   return MODE_POS;
      2'b01:   return MODE_NEG;
      2'b11:   return MODE_BOTH_HI;
      default: return MODE_DAMPED;
    endcase
  endfunction

  // Per-leg requested side: 1 = supply, 0 = ground. Bit index = leg.
  function automatic logic [NUM_LEGS-1:0] mode_targets(input bridge_mode_e m);
    logic [NUM_LEGS-1:0] t;
    t = '0;
    case (m)
      MODE_POS:     t[LEG_PLUS]  = 1'b1;
      MODE_NEG:     t[LEG_MINUS] = 1'b1;
      MODE_BOTH_HI: t            = '1;
      default:      t            = '0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/pwmb_sync.sv
module pwmb_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pwmb_leg.sv
module pwmb_leg
  import pwmb_pkg::*;
#(
  parameter int DEAD_CYC   = 2,
  parameter int MIN_PW_CYC = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_i,
  input  logic      want_i,
  output leg_gate_t gate_o
);

  localparam int CNT_MAX = (DEAD_CYC > MIN_PW_CYC) ? DEAD_CYC : MIN_PW_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t DEAD_C  = cnt_t'(DEAD_CYC);
  localparam cnt_t MINPW_C = cnt_t'(MIN_PW_CYC);
  localparam cnt_t SAT_C   = cnt_t'(CNT_MAX);
  localparam cnt_t ONE_C   = cnt_t'(1);

  function automatic cnt_t bump(input cnt_t c);
    return (c >= SAT_C) ? c : c + ONE_C;
  endfunction

  logic hi_q, lo_q, pend_q, fresh_q;
  cnt_t cnt_q;
  logic hi_d, lo_d, pend_d, fresh_d;
  cnt_t cnt_d;

  // Named events for the checks below
  logic aged_w, dead_done_w, side_w, turn_off_w, turn_on_w;
  assign aged_w      = cnt_q >= MINPW_C;
  assign dead_done_w = cnt_q >= DEAD_C;
  assign side_w      = fresh_q ? want_i : pend_q;

  always_comb begin
    hi_d       = hi_q;
    lo_d       = lo_q;
    pend_d     = pend_q;
    fresh_d    = fresh_q;
    cnt_d      = cnt_q;
    turn_off_w = 1'b0;
    turn_on_w  = 1'b0;
    if (!en_i) begin
      hi_d    = 1'b0;
      lo_d    = 1'b0;
      cnt_d   = '0;
      fresh_d = 1'b1;
    end else if (hi_q) begin
      if (!want_i && aged_w) begin
        hi_d       = 1'b0;
        cnt_d      = ONE_C;
        pend_d     = 1'b0;
        fresh_d    = 1'b0;
        turn_off_w = 1'b1;
      end else begin
        cnt_d = bump(cnt_q);
      end
    end else if (lo_q) begin
      if (want_i && aged_w) begin
        lo_d       = 1'b0;
        cnt_d      = ONE_C;
        pend_d     = 1'b1;
        fresh_d    = 1'b0;
        turn_off_w = 1'b1;
      end else begin
        cnt_d = bump(cnt_q);
      end
    end else begin
      if (dead_done_w) begin
        hi_d      = side_w;
        lo_d      = !side_w;
        cnt_d     = ONE_C;
        turn_on_w = 1'b1;
      end else begin
        cnt_d = bump(cnt_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
      pend_q  <= 1'b0;
      fresh_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      pend_q  <= pend_d;
      fresh_q <= fresh_d;
      cnt_q   <= cnt_d;
    end
  end

  assign gate_o.hi = hi_q;
  assign gate_o.lo = lo_q;

  // Observation counters for the timing checks (saturating)
  cnt_t off_len_q, hi_len_q, lo_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_len_q <= '0;
      hi_len_q  <= '0;
      lo_len_q  <= '0;
    end else begin
      off_len_q <= (!hi_q && !lo_q) ? bump(off_len_q) : '0;
      hi_len_q  <= hi_q ? bump(hi_len_q) : '0;
      lo_len_q  <= lo_q ? bump(lo_len_q) : '0;
    end
  end

  assert_no_shoot_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_q && lo_q));

  assert_disable_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!hi_q && !lo_q));

  assert_dead_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hi_q) || $rose(lo_q)) |-> (off_len_q >= DEAD_C));

  assert_min_on_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hi_q) && $past(en_i)) |-> (hi_len_q >= MINPW_C));

  assert_min_on_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lo_q) && $past(en_i)) |-> (lo_len_q >= MINPW_C));

  assert_event_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(turn_on_w && turn_off_w));

endmodule

// File: rtl/pwm_bridge_decoder.sv
module pwm_bridge_decoder
  import pwmb_pkg::*;
#(
  parameter int DEAD_CYC    = 2,
  parameter int MIN_PW_CYC  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic pwm_p,
  input  logic pwm_n,
  output logic a_hi,
  output logic a_lo,
  output logic b_hi,
  output logic b_lo
);

  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0]   raw_w, sync_w;
  logic                en_s_w;
  bridge_mode_e        mode_w;
  logic [NUM_LEGS-1:0] targ_w;
  leg_gate_t           gate_w [NUM_LEGS];

  assign raw_w = {enable, pwm_p, pwm_n};

  pwmb_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_w),
    .sync_o  (sync_w)
  );

  assign en_s_w = sync_w[2];
  assign mode_w = decode_mode(sync_w[1], sync_w[0]);
  assign targ_w = mode_targets(mode_w);

  generate
    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
      pwmb_leg #(.DEAD_CYC(DEAD_CYC), .MIN_PW_CYC(MIN_PW_CYC)) u_leg (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_s_w),
        .want_i (targ_w[g]),
        .gate_o (gate_w[g])
      );
    end
  endgenerate

  assign a_hi = gate_w[LEG_PLUS].hi;
  assign a_lo = gate_w[LEG_PLUS].lo;
  assign b_hi = gate_w[LEG_MINUS].hi;
  assign b_lo = gate_w[LEG_MINUS].lo;

  // Held damped request drives both legs to ground once settled
  assert_damped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s_w && $past(en_s_w) && mode_w == MODE_DAMPED && $past(mode_w) == MODE_DAMPED
      && a_lo && b_lo) |=> (a_lo && b_lo));

endmodule

// File: tb/tb_pwm_bridge_decoder.sv
module tb_pwm_bridge_decoder;

  localparam int CLK_P = 10;
  localparam int DEAD  = 2;
  localparam int MINPW = 5;

  logic clk = 1'b0;
  logic rst_n, enable, pwm_p, pwm_n;
  logic a_hi, a_lo, b_hi, b_lo;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  bit cmp_on = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pwm_bridge_decoder #(.DEAD_CYC(DEAD), .MIN_PW_CYC(MINPW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pwm_p(pwm_p), .pwm_n(pwm_n),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int gates();
    return {a_hi, a_lo, b_hi, b_lo};
  endfunction

  // Behavioural reference: a delay line for the pins, then per-leg side tracking
  int m_p1[3], m_p2[3];            // [0]=enable [1]=p [2]=n
  int m_side[2];                   // 0 off, 1 supply, 2 ground
  int m_age[2], m_next[2], m_new[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin m_p1[i] = 0; m_p2[i] = 0; end
      for (int l = 0; l < 2; l++) begin
        m_side[l] = 0; m_age[l] = 0; m_next[l] = 0; m_new[l] = 1;
      end
    end else begin
      for (int l = 0; l < 2; l++) begin
        int req;
        req = (l == 0) ? m_p2[1] : m_p2[2];
        if (m_p2[0] == 0) begin
          m_side[l] = 0; m_age[l] = 0; m_new[l] = 1;
        end else if (m_side[l] != 0) begin
          if (((m_side[l] == 1) != (req == 1)) && m_age[l] >= MINPW) begin
            m_next[l] = req; m_side[l] = 0; m_age[l] = 1; m_new[l] = 0;
          end else m_age[l]++;
        end else begin
          if (m_age[l] >= DEAD) begin
            m_side[l] = ((m_new[l] ? req : m_next[l]) == 1) ? 1 : 2;
            m_age[l] = 1;
          end else m_age[l]++;
        end
      end
      for (int i = 0; i < 3; i++) m_p2[i] = m_p1[i];
      m_p1[0] = enable; m_p1[1] = pwm_p; m_p1[2] = pwm_n;
    end
  end

  // Per-cycle comparison (pipeline latency R9, exclusion R6)
  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      int exp;
      exp = {m_side[0] == 1, m_side[0] == 2, m_side[1] == 1, m_side[1] == 2};
      chk(gates() == exp, "R9 model", gates(), exp);
      chk(!(a_hi && a_lo) && !(b_hi && b_lo), "R6", gates(), exp);
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k, ok_all, ref_g;
    int unsigned lfsr;
    rst_n = 1'b0; enable = 1'b1; pwm_p = 1'b1; pwm_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(gates() == 0, "R6 reset", gates(), 0);
    enable = 1'b0;
    rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (6) @(negedge clk);
    chk(gates() == 0, "R1 disabled", gates(), 0);

    // R11: enable rises, turn-on after 3+DEAD edges
    enable = 1'b1;
    k = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); k++;
      if (a_hi) break;
    end
    chk(k == 3 + DEAD, "R11 enable turn-on", k, 3 + DEAD);
    repeat (20) @(negedge clk);
    chk(gates() == 4'b1001, "R3 positive", gates(), 4'b1001);

    // R10: constant input, constant output
    ok_all = 1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (gates() != 4'b1001) ok_all = 0;
    end
    chk(ok_all == 1, "R10 stuck input", ok_all, 1);

    pwm_p = 1'b0; pwm_n = 1'b0;
    repeat (20) @(negedge clk);
    chk(gates() == 4'b0101, "R2 damped", gates(), 4'b0101);

    // R9 latency then R7 dead gap on the plus leg
    pwm_p = 1'b1;
    k = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); k++;
      if (!a_lo) break;
    end
    chk(k == 3, "R9 latency", k, 3);
    k = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (a_hi) break;
      k++;
    end
    chk(k == DEAD, "R7 dead gap", k, DEAD);
    repeat (20) @(negedge clk);

    // R8: one-cycle low request is stretched to MINPW
    pwm_p = 1'b0;
    @(negedge clk);
    pwm_p = 1'b1;
    for (int i = 0; i < 30; i++) begin
      if (a_lo) break;
      @(negedge clk);
    end
    k = 0;
    for (int i = 0; i < 40; i++) begin
      if (!a_lo) break;
      k++;
      @(negedge clk);
    end
    chk(k == MINPW, "R8 stretched pulse", k, MINPW);
    repeat (20) @(negedge clk);
    chk(gates() == 4'b1001, "R8 return to positive", gates(), 4'b1001);

    pwm_p = 1'b0; pwm_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(gates() == 4'b0110, "R4 negative", gates(), 4'b0110);
    pwm_p = 1'b1; pwm_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(gates() == 4'b1010, "R5 both high", gates(), 4'b1010);

    // R1: disable, then PWM activity must not reach the gates
    enable = 1'b0;
    repeat (3) @(negedge clk);
    chk(gates() == 0, "R1 off after 3 edges", gates(), 0);
    ok_all = 1;
    for (int i = 0; i < 40; i++) begin
      pwm_p = i[0]; pwm_n = i[1];
      @(negedge clk);
      if (gates() != 0) ok_all = 0;
    end
    chk(ok_all == 1, "R1 ignores PWM while disabled", ok_all, 1);

    // Pseudo-random phase: model compare every cycle (R7, R8 reversals)
    enable = 1'b1;
    lfsr = 32'h1ACE5;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:0] < 4'd5) pwm_p = lfsr[7];
      if (lfsr[11:8] < 4'd5) pwm_n = lfsr[13];
      if (lfsr[23:17] == 7'd0) enable = ~enable;
      if (!enable && lfsr[26:24] == 3'd0) enable = 1'b1;
      @(negedge clk);
    end
    enable = 1'b1; pwm_p = 1'b0; pwm_n = 1'b1;
    repeat (30) @(negedge clk);
    ref_g = 4'b0110;
    chk(gates() == ref_g, "R4 after random phase", gates(), ref_g);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule